// File: doc/BRIEF.md
# Buffered Four-Channel Input Capture Unit

This block timestamps external events against a free-running counter. It has four capture channels, A to D. Each channel watches its own input pin. When the selected edge arrives, the channel stores the current counter value in its own capture register and raises a status flag. The counter comes from outside the block as a plain up-counting value.

Channel C can act as a history register for channel A, and channel D for channel B. Each pair has its own buffer-enable bit. When buffering is on, an event on the main channel keeps the previous timestamp by moving it into the partner register, and loads the new one in the same clock. The partner's pin then stops capturing and becomes a plain edge-triggered interrupt source.

A small CPU port gives access to the registers: one control register, one status register, and four read-only capture registers. Per-channel interrupt outputs follow the status flags, gated by per-channel enable bits. To clear a flag, the CPU must first read it while it is set, and then write zero to that bit.

Top module: `cap4_unit`

Register addresses on `cpu_addr`:

| Address | Register | Access |
|---|---|---|
| 0 | control | read/write |
| 1 | status | flag clearing as in R7 |
| 2 | capture A | read-only |
| 3 | capture B | read-only |
| 4 | capture C | read-only |
| 5 | capture D | read-only |

Control register fields:

| Bits | Field |
|---|---|
| 0 | buffer enable for pair A/C |
| 1 | buffer enable for pair B/D |
| 5:2 | edge select for channels A, B, C, D (1 = rising, 0 = falling) |
| 9:6 | interrupt enable for channels A, B, C, D |

Status register bits 3:0 hold the flags of channels A, B, C and D, in that order.

## Requirements
- R1: With its pair's buffer bit at 0, a selected edge on a channel pin loads the counter value into that channel's capture register and sets that channel's status flag.
- R2: With the buffer bit of a pair at 1 (control bit 0 for A/C, bit 1 for B/D), a selected edge on the main pin (A or B) moves the old main register value into the partner register (C or D) and loads the counter value into the main register, both on the same clock, and sets the main flag.
- R3: With a pair's buffer bit at 1, a selected edge on the partner pin (C or D) leaves every capture register unchanged and sets only the partner flag.
- R4: Control bits 5:2 select the edge for channels A to D: 1 means rising, 0 means falling. An edge of the other polarity causes no capture and no flag.
- R5: A pin change that is sampled at clock edge k is captured with the counter value present at clock edge k+2. This allows for the two-flop synchronizer and the edge detect.
- R6: Only hardware sets a flag. A CPU write of 1 to a status bit has no effect, whether the flag is 0 or 1.
- R7: A flag is cleared only by a write of 0 to its status bit after a status read that saw that flag at 1. A write of 0 without such a read leaves the flag set.
- R8: If an event sets a flag in the same clock as a valid clearing write, the flag stays 1.
- R9: After reset, the flags, the capture registers and the control register are all 0, and every interrupt output is 0.
- R10: Interrupt output i is high exactly when flag i is 1 and interrupt-enable bit 6+i of the control register is 1.
- R11: CPU writes to the capture register addresses (2 to 5) have no effect on the stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_in | input | CNT_W | Free-running counter value |
| cap_pin | input | 4 | Asynchronous capture pins; bit 0 = A … bit 3 = D |
| cpu_addr | input | 3 | Register address |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_rd | input | 1 | Read strobe, one cycle per read |
| cpu_wdata | input | CNT_W | Write data |
| cpu_rdata | output | CNT_W | Read data for `cpu_addr`, valid while `cpu_rd` is high |
| irq | output | 4 | Per-channel interrupt requests |

## Verification
The embedded assertions check every cycle that a capture loads the counter of the previous clock, and that buffered shifts move the old main value into the partner. They also check that a partner register holds its value in buffer mode, and that a flag never rises without a hardware event. Two more rules are checked the same way: a flag never falls unless it was armed by a read, and a set always beats a clear.

The bench alone shows the end-to-end behaviour:
- the exact capture latency through the synchronizer;
- edge polarity selection;
- the read-then-write-zero protocol as the CPU sees it;
- the timed set-versus-clear collision;
- interrupt masking;
- the register values after reset.

// File: rtl/cap4_pkg.sv
// Package: shared constants and the control register layout for cap4_unit.
// Assumes: four channels, indices 0..3 map to A..D; pair p is (p, p+2).
package cap4_pkg;

    localparam int NUM_CH   = 4;
    localparam int NUM_PAIR = NUM_CH / 2;
    localparam int ADDR_W   = 3;

    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_STAT  = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_CAP_A = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_CAP_B = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_CAP_C = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_CAP_D = 3'd5;

    // Control register, LSB first: buf_ac, buf_bd, rise_sel[3:0], irq_en[3:0]
    typedef struct packed {
        logic [NUM_CH-1:0] irq_en;
        logic [NUM_CH-1:0] rise_sel;
        logic              buf_bd;
        logic              buf_ac;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/cap4_edge_detect.sv
// Module: cap4_edge_detect
// Synchronizes N_CH asynchronous pins through two flops, then emits a
// one-cycle pulse per channel on the polarity chosen by rise_sel.
// Assumes: pins may change at any time; rise_sel is a quasi-static control.
module cap4_edge_detect #(
    parameter int N_CH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] pin_i,
    input  logic [N_CH-1:0] rise_sel,
    output logic [N_CH-1:0] edge_o
);

    logic [N_CH-1:0] meta_q;
    logic [N_CH-1:0] sync_q;
    logic [N_CH-1:0] prev_q;
    logic [N_CH-1:0] rise_w;
    logic [N_CH-1:0] fall_w;

    // Two-stage synchronizer plus one history flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise_w = sync_q & ~prev_q;
    assign fall_w = ~sync_q & prev_q;

    genvar ch;
    generate
        for (ch = 0; ch < N_CH; ch++) begin : g_sel
            // Pick rising or falling detector per channel
            assign edge_o[ch] = rise_sel[ch] ? rise_w[ch] : fall_w[ch];

            AST_RISE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
                (edge_o[ch] && rise_sel[ch]) |=> !(edge_o[ch] && rise_sel[ch])); // R4
        end
    endgenerate

endmodule

// File: rtl/cap4_pair.sv
// Module: cap4_pair
// One main/partner capture pair. In direct mode each register captures on
// its own event. In buffer mode a main event shifts main into partner and
// loads the counter into main; partner events capture nothing.
// Assumes: ev_main / ev_buf are single-cycle pulses from the edge detector.
module cap4_pair #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             buf_en,
    input  logic             ev_main,
    input  logic             ev_buf,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap_main,
    output logic [CNT_W-1:0] cap_buf
);

    // Main register: loads the counter on every main event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_main <= '0;
        end else if (ev_main) begin
            cap_main <= cnt;
        end
    end

    // Partner register: shift from main when buffered, direct capture otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_buf <= '0;
        end else if (buf_en) begin
            if (ev_main) begin
                cap_buf <= cap_main;
            end
        end else if (ev_buf) begin
            cap_buf <= cnt;
        end
    end

    AST_MAIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ev_main |=> (cap_main == $past(cnt))); // R1
    AST_MAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_main |=> $stable(cap_main)); // R1
    AST_BUF_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_main && buf_en) |=> (cap_buf == $past(cap_main))); // R2
    AST_BUF_PIN_NOCAP: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_en && !ev_main) |=> $stable(cap_buf)); // R3

endmodule

// File: rtl/cap4_flags.sv
// Module: cap4_flags
// Status flags with read-then-write-zero clearing. A status read that sees a
// flag at 1 arms it; a later write of 0 to an armed bit clears it. A hardware
// set in the same cycle as a clear wins and disarms the bit.
// Assumes: rd_stat / wr_stat are single-cycle strobes already address-decoded.
module cap4_flags #(
    parameter int N_CH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] set_i,
    input  logic            rd_stat,
    input  logic            wr_stat,
    input  logic [N_CH-1:0] wdata,
    output logic [N_CH-1:0] flag_o
);

    logic [N_CH-1:0] armed_q;
    logic [N_CH-1:0] clr_w;
    logic [N_CH-1:0] flag_n;
    logic [N_CH-1:0] armed_n;

    // Next-state computation for flags and their arm bits
    always_comb begin
        clr_w   = {N_CH{wr_stat}} & ~wdata & armed_q;
        flag_n  = set_i | (flag_o & ~clr_w);
        armed_n = flag_n & ((armed_q & ~clr_w) | ({N_CH{rd_stat}} & flag_o));
    end

    // Flag and arm state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o  <= '0;
            armed_q <= '0;
        end else begin
            flag_o  <= flag_n;
            armed_q <= armed_n;
        end
    end

    AST_HW_SET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_o & ~$past(flag_o) & ~$past(set_i)) == '0)); // R6
    AST_CLR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~flag_o & $past(flag_o) & ~$past(armed_q)) == '0)); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> (($past(set_i) & ~flag_o) == '0)); // R8

endmodule

// File: rtl/cap4_unit.sv
// Module: cap4_unit (top)
// Four-channel buffered input capture unit with CPU register port,
// read-then-write-zero status flags and masked interrupt outputs.
// Assumes: cnt_in is synchronous to clk; CNT_W >= control register width.
module cap4_unit
    import cap4_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic [NUM_CH-1:0] cap_pin,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [CNT_W-1:0]  cpu_wdata,
    output logic [CNT_W-1:0]  cpu_rdata,
    output logic [NUM_CH-1:0] irq
);

    localparam int PAD_W = CNT_W - CTRL_W;

    ctrl_t                         ctrl_q;
    logic [NUM_CH-1:0]             edge_w;
    logic [NUM_CH-1:0]             flag_w;
    logic [NUM_PAIR-1:0]           buf_en_w;
    logic [NUM_CH-1:0][CNT_W-1:0]  cap_w;
    logic                          wr_ctrl;
    logic                          wr_stat;
    logic                          rd_stat;
    logic                          unused_wdata_hi;

    assign wr_ctrl         = cpu_wr && (cpu_addr == ADDR_CTRL);
    assign wr_stat         = cpu_wr && (cpu_addr == ADDR_STAT);
    assign rd_stat         = cpu_rd && (cpu_addr == ADDR_STAT);
    assign buf_en_w        = {ctrl_q.buf_bd, ctrl_q.buf_ac};
    assign unused_wdata_hi = ^cpu_wdata[CNT_W-1:CTRL_W];

    // Control register: written only through its own address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= ctrl_t'(cpu_wdata[CTRL_W-1:0]);
        end
    end

    cap4_edge_detect #(.N_CH(NUM_CH)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_i    (cap_pin),
        .rise_sel (ctrl_q.rise_sel),
        .edge_o   (edge_w)
    );

    genvar p;
    generate
        for (p = 0; p < NUM_PAIR; p++) begin : g_pair
            cap4_pair #(.CNT_W(CNT_W)) u_pair (
                .clk      (clk),
                .rst_n    (rst_n),
                .buf_en   (buf_en_w[p]),
                .ev_main  (edge_w[p]),
                .ev_buf   (edge_w[p+NUM_PAIR]),
                .cnt      (cnt_in),
                .cap_main (cap_w[p]),
                .cap_buf  (cap_w[p+NUM_PAIR])
            );
        end
    endgenerate

    cap4_flags #(.N_CH(NUM_CH)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (edge_w),
        .rd_stat (rd_stat),
        .wr_stat (wr_stat),
        .wdata   (cpu_wdata[NUM_CH-1:0]),
        .flag_o  (flag_w)
    );

    // Interrupt outputs: flag gated by its enable bit
    assign irq = flag_w & ctrl_q.irq_en;

    // Read data mux, zero when no read strobe
    always_comb begin
        cpu_rdata = '0;
        if (cpu_rd) begin
            case (cpu_addr)
                ADDR_CTRL:  cpu_rdata = {{PAD_W{1'b0}}, ctrl_q};
                ADDR_STAT:  cpu_rdata = {{(CNT_W-NUM_CH){1'b0}}, flag_w};
                ADDR_CAP_A: cpu_rdata = cap_w[0];
                ADDR_CAP_B: cpu_rdata = cap_w[1];
                ADDR_CAP_C: cpu_rdata = cap_w[2];
                ADDR_CAP_D: cpu_rdata = cap_w[3];
                default:    cpu_rdata = '0;
            endcase
        end
    end

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(ctrl_q)); // R4
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq & ~flag_w) == '0)); // R10

endmodule

// File: tb/cap4_unit_tb.sv
// Bench for cap4_unit: a vector table walked by one loop, then directed tests
// for reset, capture latency, flag clearing protocol, interrupts and collisions.
module cap4_unit_tb_top;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cnt_in = '0;
    logic [3:0]    cap_pin = '0;
    logic [2:0]    cpu_addr = '0;
    logic          cpu_wr = 1'b0;
    logic          cpu_rd = 1'b0;
    logic [CW-1:0] cpu_wdata = '0;
    logic [CW-1:0] cpu_rdata;
    logic [3:0]    irq;

    int n_checks = 0;
    int n_fail   = 0;
    logic [CW-1:0] rd_val;

    always #10 clk = ~clk;

    cap4_unit #(.CNT_W(CW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_in    (cnt_in),
        .cap_pin   (cap_pin),
        .cpu_addr  (cpu_addr),
        .cpu_wr    (cpu_wr),
        .cpu_rd    (cpu_rd),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [2:0] a, input logic [CW-1:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [2:0] a, output logic [CW-1:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Vector: {ctrl[9:0], pins[3:0], cnt[15:0], read addr[2:0], expected[15:0]}
    localparam int NV = 13;
    localparam logic [48:0] VEC [NV] = '{
        {10'h03C, 4'b0001, 16'h1111, 3'd2, 16'h1111}, // R1 A rises, captured
        {10'h03C, 4'b0011, 16'h2222, 3'd3, 16'h2222}, // R1 B rises, captured
        {10'h03C, 4'b0010, 16'h3333, 3'd2, 16'h1111}, // R4 A falls, rising selected
        {10'h038, 4'b0011, 16'h4444, 3'd2, 16'h1111}, // R4 A rises, falling selected
        {10'h038, 4'b0010, 16'h5555, 3'd2, 16'h5555}, // R4 A falls, falling selected
        {10'h03E, 4'b0000, 16'h6666, 3'd3, 16'h2222}, // R4 B falls, ignored
        {10'h03E, 4'b0010, 16'h7777, 3'd5, 16'h2222}, // R2 old B moved to D
        {10'h03E, 4'b0010, 16'h8888, 3'd3, 16'h7777}, // R2 new B loaded
        {10'h03E, 4'b1010, 16'h9999, 3'd5, 16'h2222}, // R3 D pin captures nothing
        {10'h03F, 4'b1011, 16'hAAAA, 3'd4, 16'h5555}, // R2 old A moved to C
        {10'h03F, 4'b1111, 16'hBBBB, 3'd4, 16'h5555}, // R3 C pin captures nothing
        {10'h03F, 4'b1111, 16'hCCCC, 3'd2, 16'hAAAA}, // R2 A holds new value
        {10'h03F, 4'b1111, 16'hDDDD, 3'd1, 16'h000F}  // R1 R3 all four flags set
    };

    task automatic summary_and_finish();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary_and_finish();
    end

    initial begin
        wait_n(3);
        @(negedge clk); rst_n = 1'b1;

        // Table-driven walk
        for (int v = 0; v < NV; v++) begin
            cpu_write(3'd0, {6'd0, VEC[v][48:39]});
            @(negedge clk);
            cap_pin = VEC[v][38:35];
            cnt_in  = VEC[v][34:19];
            wait_n(5);
            cpu_read(VEC[v][18:16], rd_val);
            check($sformatf("vector %0d (R1 R2 R3 R4)", v), rd_val, VEC[v][15:0]);
        end

        // R9: reset state
        @(negedge clk); rst_n = 1'b0; cap_pin = '0; cnt_in = '0;
        wait_n(3);
        @(negedge clk); rst_n = 1'b1;
        check("R9 irq", {12'd0, irq}, 16'h0000);
        for (int a = 0; a < 6; a++) begin
            cpu_read(a[2:0], rd_val);
            check($sformatf("R9 reg %0d", a), rd_val, 16'h0000);
        end

        // R5: capture latency with a moving counter
        cpu_write(3'd0, 16'h007C);
        @(negedge clk); cap_pin[1] = 1'b1; cnt_in = 16'h0100;
        @(negedge clk); cnt_in = 16'h0101;
        @(negedge clk); cnt_in = 16'h0102;
        @(negedge clk); cnt_in = 16'h0103;
        @(negedge clk); cnt_in = 16'h0104;
        wait_n(2);
        cpu_read(3'd3, rd_val);
        check("R5 latency", rd_val, 16'h0102);

        // R7: write 0 without a prior read leaves the flag set
        cpu_write(3'd1, 16'h0000);
        cpu_read(3'd1, rd_val);
        check("R7 no-read write", rd_val, 16'h0002);

        // R6: write of 1 neither clears a set flag nor sets a clear one
        cpu_write(3'd1, 16'h000F);
        cpu_read(3'd1, rd_val);
        check("R6 write ones", rd_val, 16'h0002);

        // R7: read then write 0 clears
        cpu_write(3'd1, 16'h0000);
        cpu_read(3'd1, rd_val);
        check("R7 clear", rd_val, 16'h0000);

        // R10: interrupt follows flag and enable
        @(negedge clk); cap_pin[0] = 1'b1; cnt_in = 16'h0A0A;
        wait_n(5);
        check("R10 irq enabled", {12'd0, irq}, 16'h0001);
        cpu_read(3'd1, rd_val);
        check("R10 flag A", rd_val, 16'h0001);
        cpu_write(3'd0, 16'h003C);
        wait_n(1);
        check("R10 irq masked", {12'd0, irq}, 16'h0000);

        // R8: hardware set collides with a valid clear
        @(negedge clk); cap_pin[0] = 1'b0;
        wait_n(5);
        cpu_read(3'd1, rd_val);
        @(negedge clk); cap_pin[0] = 1'b1; cnt_in = 16'h0B0B;
        @(negedge clk);
        @(negedge clk); cpu_addr = 3'd1; cpu_wdata = 16'h0000; cpu_wr = 1'b1;
        @(negedge clk); cpu_wr = 1'b0;
        wait_n(2);
        cpu_read(3'd1, rd_val);
        check("R8 set wins", rd_val, 16'h0001);

        // R11: capture registers ignore CPU writes
        cpu_write(3'd2, 16'h1234);
        cpu_read(3'd2, rd_val);
        check("R11 read-only A", rd_val, 16'h0B0B);

        summary_and_finish();
    end

endmodule